// File: doc/BRIEF.md
# Status-Flag Integer ALU

This block is a two's-complement integer ALU with a status register built around it. It takes two operands, an operation code and a width select, and returns a result together with five condition flags: carry, zero, negative, overflow and digit carry. Each operation can run on the full 16-bit word or on the low byte only. In byte mode the upper byte of the result is taken from the first operand unchanged.

The combinational datapath handles add, subtract, the three bitwise logic operations and single-bit shifts. The add-with-carry and subtract-with-borrow operations take their incoming carry from the stored carry flag. Multi-word arithmetic is built by chaining these operations. On subtraction, carry and digit carry mean "no borrow". A registered wrapper captures the result on every accepted operation. It rewrites only the flags that the operation class affects, so later instructions can still test flags left by earlier ones.

Top module: `flag_alu`

## Requirements
- R1: While `rst` is high at a clock edge, `result_o` and `flags_o` become zero after that edge. The flag positions in `flags_o` are: bit 0 carry (C), bit 1 zero (Z), bit 2 negative (N), bit 3 overflow (OV), bit 4 digit carry (DC).
- R2: Operation codes are ADD=0, ADDC=1, SUB=2, SUBB=3, AND=4, IOR=5, XOR=6, SL=7, LSR=8, ASR=9. ADD produces a+b and ADDC produces a+b+C, where C is the stored carry. C is set to the carry out of the active width's top bit.
- R3: SUB produces a-b and SUBB produces a-b-(1-C). C is set to 1 when no borrow occurs and to 0 when a borrow occurs.
- R4: For arithmetic operations, DC is the carry out of bit 3 into bit 4 in both widths. On subtraction it is 1 when the low nibble needs no borrow.
- R5: For addition, OV is set when both operands have the same sign and the result's sign differs. For subtraction, OV is set when the operands differ in sign and the result's sign differs from that of a.
- R6: Z is set when the active-width result is zero. N is the top bit of the active width (bit 15 for a word, bit 7 for a byte). Arithmetic operations update all five flags.
- R7: With `byte_i`=1, `result_o[15:8]` equals `a_i[15:8]`, and every flag is derived from bits 7:0 only.
- R8: AND, IOR and XOR update only Z and N. C, OV and DC keep their previous values.
- R9: SL shifts a left and inserts 0, setting C to the active width's old top bit. LSR shifts a right and inserts 0, while ASR shifts right and replicates the sign bit; both set C to the old bit 0. Shifts update C, Z and N and leave OV and DC unchanged.
- R10: Codes 10 to 15 return `a_i` as the result and change no flag.
- R11: With `valid_i`=0 at an edge, `result_o` and `flags_o` hold their values.
- R12: With `valid_i`=1 at an edge, the result and flags appear at the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Execute the presented operation at this edge |
| op_i | input | 4 | Operation code |
| byte_i | input | 1 | 1 = byte width, 0 = word width |
| a_i | input | 16 | First operand (minuend, shift source, byte-mode upper-half source) |
| b_i | input | 16 | Second operand |
| result_o | output | 16 | Registered result |
| flags_o | output | 5 | Registered status flags {DC, OV, N, Z, C} |

## Verification
The hardest cases to reach involve ADDC and SUBB. Their result depends on a carry flag that only an earlier operation can set, and that flag can be left untouched by logic operations or rewritten by shifts in between. The bench therefore keeps its own shadow copy of the flags and runs long random sequences that mix all operation classes in both widths, so the chained ops see both values of the stored carry. Directed pairs then set C to a known value before a chained operation, and hit nibble and sign boundaries exactly.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBB = 4'd3,
    OP_AND  = 4'd4,
    OP_IOR  = 4'd5,
    OP_XOR  = 4'd6,
    OP_SL   = 4'd7,
    OP_LSR  = 4'd8,
    OP_ASR  = 4'd9
  } alu_op_e;

  localparam int FLAG_N = 5;
  localparam int FL_C   = 0;
  localparam int FL_Z   = 1;
  localparam int FL_N   = 2;
  localparam int FL_OV  = 3;
  localparam int FL_DC  = 4;

  localparam logic [FLAG_N-1:0] UPD_ARITH = 5'b11111;
  localparam logic [FLAG_N-1:0] UPD_LOGIC = 5'b00110;
  localparam logic [FLAG_N-1:0] UPD_SHIFT = 5'b00111;
  localparam logic [FLAG_N-1:0] UPD_NONE  = 5'b00000;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W  = 16,
  parameter int BW = 8,
  parameter int NW = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  input  logic         byte_sel,
  output logic [W-1:0] res,
  output logic         c_out,
  output logic         dc_out,
  output logic         ov_out
);
  logic [W-1:0]  b_eff;
  logic [W:0]    w_sum;
  logic [BW:0]   l_sum;
  logic [NW:0]   n_sum;

  always_comb begin
    b_eff = sub ? ~b : b;
    w_sum = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
    l_sum = {1'b0, a[BW-1:0]} + {1'b0, b_eff[BW-1:0]} + {{BW{1'b0}}, cin};
    n_sum = {1'b0, a[NW-1:0]} + {1'b0, b_eff[NW-1:0]} + {{NW{1'b0}}, cin};
    dc_out = n_sum[NW];
    if (byte_sel) begin
      res    = {a[W-1:BW], l_sum[BW-1:0]};
      c_out  = l_sum[BW];
      ov_out = (a[BW-1] == b_eff[BW-1]) && (l_sum[BW-1] != a[BW-1]);
    end else begin
      res    = w_sum[W-1:0];
      c_out  = w_sum[W];
      ov_out = (a[W-1] == b_eff[W-1]) && (w_sum[W-1] != a[W-1]);
    end
  end
endmodule

// File: rtl/alu_bitops.sv
module alu_bitops
  import alu_pkg::*;
#(
  parameter int W  = 16,
  parameter int BW = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   op,
  input  logic         byte_sel,
  output logic [W-1:0] res,
  output logic         c_out
);
  logic [W-1:0]  w_res;
  logic          w_c;
  logic [BW-1:0] l_res;
  logic          l_c;

  always_comb begin
    w_c = 1'b0;
    l_c = 1'b0;
    case (op)
      OP_AND: begin w_res = a & b; l_res = a[BW-1:0] & b[BW-1:0]; end
      OP_IOR: begin w_res = a | b; l_res = a[BW-1:0] | b[BW-1:0]; end
      OP_XOR: begin w_res = a ^ b; l_res = a[BW-1:0] ^ b[BW-1:0]; end
      OP_SL: begin
        w_res = {a[W-2:0], 1'b0};       w_c = a[W-1];
        l_res = {a[BW-2:0], 1'b0};      l_c = a[BW-1];
      end
      OP_LSR: begin
        w_res = {1'b0, a[W-1:1]};       w_c = a[0];
        l_res = {1'b0, a[BW-1:1]};      l_c = a[0];
      end
      OP_ASR: begin
        w_res = {a[W-1], a[W-1:1]};     w_c = a[0];
        l_res = {a[BW-1], a[BW-1:1]};   l_c = a[0];
      end
      default: begin w_res = a; l_res = a[BW-1:0]; end
    endcase
    res   = byte_sel ? {a[W-1:BW], l_res} : w_res;
    c_out = byte_sel ? l_c : w_c;
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int W  = 16,
  parameter int BW = 8,
  parameter int NW = 4
) (
  input  logic [W-1:0]      a,
  input  logic [W-1:0]      b,
  input  logic [3:0]        op,
  input  logic              byte_sel,
  input  logic              c_in,
  output logic [W-1:0]      res,
  output logic [FLAG_N-1:0] flg,
  output logic [FLAG_N-1:0] upd
);
  logic         is_sub, use_c, cin;
  logic [W-1:0] as_res, bo_res;
  logic         as_c, as_dc, as_ov, bo_c;

  assign is_sub = (op == OP_SUB) || (op == OP_SUBB);
  assign use_c  = (op == OP_ADDC) || (op == OP_SUBB);
  assign cin    = use_c ? c_in : is_sub;

  alu_addsub #(.W(W), .BW(BW), .NW(NW)) u_as (
    .a(a), .b(b), .cin(cin), .sub(is_sub), .byte_sel(byte_sel),
    .res(as_res), .c_out(as_c), .dc_out(as_dc), .ov_out(as_ov)
  );

  alu_bitops #(.W(W), .BW(BW)) u_bo (
    .a(a), .b(b), .op(op), .byte_sel(byte_sel),
    .res(bo_res), .c_out(bo_c)
  );

  always_comb begin
    flg = '0;
    case (op)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBB: begin
        res = as_res;
        upd = UPD_ARITH;
        flg[FL_C]  = as_c;
        flg[FL_OV] = as_ov;
        flg[FL_DC] = as_dc;
      end
      OP_AND, OP_IOR, OP_XOR: begin
        res = bo_res;
        upd = UPD_LOGIC;
      end
      OP_SL, OP_LSR, OP_ASR: begin
        res = bo_res;
        upd = UPD_SHIFT;
        flg[FL_C] = bo_c;
      end
      default: begin
        res = a;
        upd = UPD_NONE;
      end
    endcase
    if (byte_sel) begin
      flg[FL_Z] = (res[BW-1:0] == '0);
      flg[FL_N] = res[BW-1];
    end else begin
      flg[FL_Z] = (res == '0);
      flg[FL_N] = res[W-1];
    end
  end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import alu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LANE_W = DATA_W / 2,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic              byte_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] result_o,
  output logic [FLAG_N-1:0] flags_o
);
  logic [DATA_W-1:0] core_res;
  logic [FLAG_N-1:0] core_flg, core_upd;

  alu_core #(.W(DATA_W), .BW(LANE_W), .NW(NIB_W)) u_core (
    .a(a_i), .b(b_i), .op(op_i), .byte_sel(byte_i), .c_in(flags_o[FL_C]),
    .res(core_res), .flg(core_flg), .upd(core_upd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      flags_o  <= '0;
    end else if (valid_i) begin
      result_o <= core_res;
      flags_o  <= (flags_o & ~core_upd) | (core_flg & core_upd);
    end
  end
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk
  import alu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LANE_W = DATA_W / 2
) (
  input logic              clk,
  input logic              rst,
  input logic              valid_i,
  input logic [3:0]        op_i,
  input logic              byte_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] result_o,
  input logic [FLAG_N-1:0] flags_o
);
  logic is_logic, is_shift, is_bad, is_known;
  assign is_logic = (op_i == OP_AND) || (op_i == OP_IOR) || (op_i == OP_XOR);
  assign is_shift = (op_i == OP_SL) || (op_i == OP_LSR) || (op_i == OP_ASR);
  assign is_bad   = (op_i > OP_ASR);
  assign is_known = !is_bad;

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> $stable(result_o) && $stable(flags_o));

  // R7
  byte_upper_chk: assert property (@(posedge clk) disable iff (rst)
    valid_i && byte_i |=> result_o[DATA_W-1:LANE_W] == $past(a_i[DATA_W-1:LANE_W]));

  // R8
  logic_keep_chk: assert property (@(posedge clk) disable iff (rst)
    valid_i && is_logic |=> flags_o[FL_C] == $past(flags_o[FL_C])
      && flags_o[FL_OV] == $past(flags_o[FL_OV]) && flags_o[FL_DC] == $past(flags_o[FL_DC]));

  // R9
  shift_keep_chk: assert property (@(posedge clk) disable iff (rst)
    valid_i && is_shift |=> flags_o[FL_OV] == $past(flags_o[FL_OV])
      && flags_o[FL_DC] == $past(flags_o[FL_DC]));

  // R10
  bad_op_chk: assert property (@(posedge clk) disable iff (rst)
    valid_i && is_bad |=> result_o == $past(a_i) && flags_o == $past(flags_o));

  // R6
  word_zero_chk: assert property (@(posedge clk) disable iff (rst)
    valid_i && !byte_i && is_known |=> flags_o[FL_Z] == (result_o == '0)
      && flags_o[FL_N] == result_o[DATA_W-1]);

  // R6
  byte_zero_chk: assert property (@(posedge clk) disable iff (rst)
    valid_i && byte_i && is_known |=> flags_o[FL_Z] == (result_o[LANE_W-1:0] == '0)
      && flags_o[FL_N] == result_o[LANE_W-1]);
endmodule

bind flag_alu flag_alu_chk #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .byte_i(byte_i),
  .a_i(a_i), .result_o(result_o), .flags_o(flags_o)
);

// File: tb/flag_alu_test.sv
module flag_alu_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = 4'd0;
  logic        byte_i = 1'b0;
  logic [15:0] a_i = 16'd0;
  logic [15:0] b_i = 16'd0;
  logic [15:0] result_o;
  logic [4:0]  flags_o;

  int checks = 0;
  int errors = 0;
  logic [4:0] m_flags = 5'd0;
  logic [15:0] m_res = 16'd0;

  always #4 clk = ~clk;

  flag_alu uut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .byte_i(byte_i),
    .a_i(a_i), .b_i(b_i), .result_o(result_o), .flags_o(flags_o)
  );

  initial begin
    #(8 * 190000);
    checks++; errors++;
    $display("FAIL watchdog: run did not finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [3:0] op);
    if (op <= 4'd1) return "R2";
    if (op <= 4'd3) return "R3";
    if (op <= 4'd6) return "R8";
    if (op <= 4'd9) return "R9";
    return "R10";
  endfunction

  // reference model: updates m_res and m_flags
  task automatic model(input logic [3:0] op, input logic bsel,
                       input logic [15:0] a, input logic [15:0] b);
    int w, msk, half, ua, ub, ci, r, sa, sb, sr, d;
    logic c, dc, ov;
    logic [4:0] upd, nf;
    w = bsel ? 8 : 16;
    msk = (1 << w) - 1;
    half = 1 << (w - 1);
    ua = int'(a) & msk;
    ub = int'(b) & msk;
    sa = (ua >= half) ? ua - (1 << w) : ua;
    sb = (ub >= half) ? ub - (1 << w) : ub;
    c = 0; dc = 0; ov = 0; r = ua; upd = 5'b00000;
    case (op)
      4'd0, 4'd1: begin
        ci = (op == 4'd1) ? int'(m_flags[0]) : 0;
        r = (ua + ub + ci) & msk;
        c = (ua + ub + ci) > msk;
        dc = ((ua & 15) + (ub & 15) + ci) > 15;
        sr = sa + sb + ci;
        ov = (sr >= half) || (sr < -half);
        upd = 5'b11111;
      end
      4'd2, 4'd3: begin
        ci = (op == 4'd3) ? 1 - int'(m_flags[0]) : 0;
        d = ua - ub - ci;
        r = d & msk;
        c = d >= 0;
        dc = ((ua & 15) - (ub & 15) - ci) >= 0;
        sr = sa - sb - ci;
        ov = (sr >= half) || (sr < -half);
        upd = 5'b11111;
      end
      4'd4: begin r = ua & ub; upd = 5'b00110; end
      4'd5: begin r = ua | ub; upd = 5'b00110; end
      4'd6: begin r = ua ^ ub; upd = 5'b00110; end
      4'd7: begin r = (ua << 1) & msk; c = (ua & half) != 0; upd = 5'b00111; end
      4'd8: begin r = ua >> 1; c = ua[0]; upd = 5'b00111; end
      4'd9: begin r = (ua >> 1) | (ua & half); c = ua[0]; upd = 5'b00111; end
      default: upd = 5'b00000;
    endcase
    nf = {dc, ov, (r & half) != 0, r == 0, c};
    m_flags = (m_flags & ~upd) | (nf & upd);
    m_res = bsel ? ((a & 16'hFF00) | 16'(r)) : 16'(r);
    if (op > 4'd9) m_res = a;
  endtask

  task automatic run(input logic [3:0] op, input logic bsel,
                     input logic [15:0] a, input logic [15:0] b, input string req);
    @(negedge clk);
    valid_i = 1'b1; op_i = op; byte_i = bsel; a_i = a; b_i = b;
    model(op, bsel, a, b);
    @(negedge clk);
    valid_i = 1'b0;
    check({req, " result"}, int'(result_o), int'(m_res));
    check({req, " flags"}, int'(flags_o), int'(m_flags));
  endtask

  initial begin
    void'($urandom(32'd20417));
    repeat (2) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 result", int'(result_o), 0);
    check("R1 flags", int'(flags_o), 0);

    // R2 word overflow and carry
    run(4'd0, 1'b0, 16'h7FFF, 16'h0001, "R5");
    check("R5 ov set", int'(flags_o[3]), 1);
    run(4'd0, 1'b0, 16'hFFFF, 16'h0001, "R2");
    check("R2 carry/zero", int'(flags_o[1:0]), 3);
    run(4'd1, 1'b0, 16'h0010, 16'h0020, "R2");
    check("R2 addc uses C", int'(result_o), 16'h0031);
    // R4 digit carry
    run(4'd0, 1'b0, 16'h000F, 16'h0001, "R4");
    check("R4 dc add", int'(flags_o[4]), 1);
    run(4'd2, 1'b0, 16'h0010, 16'h0001, "R4");
    check("R4 dc borrow", int'(flags_o[4]), 0);
    // R3 borrow
    run(4'd2, 1'b0, 16'h0001, 16'h0002, "R3");
    check("R3 borrow C", int'(flags_o[0]), 0);
    run(4'd3, 1'b0, 16'h0005, 16'h0002, "R3");
    check("R3 subb borrow", int'(result_o), 16'h0002);
    run(4'd2, 1'b0, 16'h8000, 16'h0001, "R5");
    check("R5 sub ov", int'(flags_o[3]), 1);
    // R7 byte mode
    run(4'd0, 1'b1, 16'hAB7F, 16'h5501, "R7");
    check("R7 upper byte", int'(result_o), 16'hAB80);
    check("R7 byte flags", int'(flags_o[3:0]), 4'b1100);
    // R8 logic keeps C/OV/DC
    run(4'd0, 1'b0, 16'hFFFF, 16'hFFFF, "R2");
    run(4'd4, 1'b0, 16'h0F0F, 16'hF0F0, "R8");
    check("R8 kept", int'({flags_o[4:3], flags_o[0]}), int'({m_flags[4:3], m_flags[0]}));
    // R9 shifts
    run(4'd9, 1'b1, 16'h1281, 16'h0000, "R9");
    check("R9 asr byte", int'(result_o), 16'h12C0);
    run(4'd7, 1'b0, 16'h8000, 16'h0000, "R9");
    check("R9 sl carry", int'(flags_o[1:0]), 3);
    // R10 bad opcode
    run(4'd12, 1'b0, 16'h1234, 16'h9999, "R10");
    // R11 idle hold, R12 latency
    @(negedge clk);
    valid_i = 1'b0; a_i = 16'hDEAD; op_i = 4'd0;
    @(negedge clk);
    check("R11 hold result", int'(result_o), int'(m_res));
    check("R11 hold flags", int'(flags_o), int'(m_flags));
    @(negedge clk);
    valid_i = 1'b1; op_i = 4'd0; byte_i = 1'b0; a_i = 16'h0100; b_i = 16'h0023;
    model(4'd0, 1'b0, 16'h0100, 16'h0023);
    @(posedge clk); #1;
    valid_i = 1'b0;
    check("R12 latency", int'(result_o), 16'h0123);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] op;
      logic bs;
      logic [15:0] a, b;
      op = 4'($urandom_range(0, 11));
      if (op == 4'd11) op = 4'(10 + $urandom_range(0, 5));
      bs = 1'($urandom_range(0, 1));
      a = 16'($urandom);
      b = 16'($urandom);
      if ($urandom_range(0, 7) == 0) b = a;
      if ($urandom_range(0, 7) == 0) a = 16'h8000 ^ 16'($urandom_range(0, 3));
      run(op, bs, a, b, req_of(op));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule